// File: doc/BRIEF.md
# UART Transfer-Clock Generator with Fractional Trim

This block produces the timing ticks for one UART channel. Four clock-enable strobes, all in the system clock domain, stand for the candidate timing sources: an internal oscillator, a low-speed oscillator, a high-speed oscillator and an external serial clock. A 2-bit select picks one strobe. For the internal and high-speed sources, a power-of-two prescaler thins the strobe stream. The surviving strobes step an 8-bit reloadable down counter. Each time that counter runs out, it emits the 16x sampling tick. A divide-by-16 stage then turns every sixteenth sampling tick into a bit-rate tick.

To reduce the rate error that an integer divider leaves, a 4-bit trim value N lengthens N of every 16 counter periods by one strobe. The lengthened periods are spread evenly over the 16-tick frame. A single enable starts and stops the whole generator. While the enable is low the generator is held in its start state, and it begins a fresh frame when the enable rises again.

Top module: `uart_tick_gen`

## Requirements
- R1: During synchronous active-low reset, and after it while `gen_en` is low, both `tick16_o` and `tick1_o` stay low.
- R2: `src_sel` picks the strobe: 0 = `stb_int`, 1 = `stb_ls`, 2 = `stb_hs`, 3 = `stb_ext`. The three unselected strobes have no effect on either output.
- R3: The first enabled cycle after `gen_en` rises loads `reload_val` and ignores that cycle's strobe. With trim 0, each following period lasts `reload_val`+1 passed strobes. `tick16_o` is high for one cycle, in the cycle after the edge that samples the last strobe of the period.
- R4: For sources 0 and 2, `div_sel` values 0, 1, 2 and 3 pass every 1st, 2nd, 4th and 8th selected strobe, counted from the enable. For sources 1 and 3, `div_sel` is ignored and every strobe passes.
- R5: Periods in a frame are numbered k = 0..15, with period 0 starting at the enable. Period k is one strobe longer when floor((k+1)*N/16) differs from floor(k*N/16), where N is `trim_val` sampled at the start of that period. Each frame thus holds N lengthened periods.
- R6: `tick1_o` pulses in the same cycle as the `tick16_o` that ends period 15 of each frame, and at no other time.
- R7: In the cycle after `gen_en` is sampled low, both outputs are low. The prescaler, the frame position and the counter restart, so the next enable begins a new frame at period 0.
- R8: A change of `reload_val` during a period does not change that period's length. The new value applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| gen_en | input | 1 | Generator enable |
| src_sel | input | 2 | Source select (0 internal, 1 low-speed, 2 high-speed, 3 external) |
| div_sel | input | 2 | Prescale ratio select, 1/(2^div_sel), for sources 0 and 2 |
| reload_val | input | 8 | Counter initial value |
| trim_val | input | 4 | Number of lengthened periods per 16-tick frame |
| stb_int | input | 1 | Internal oscillator enable strobe |
| stb_ls | input | 1 | Low-speed oscillator enable strobe |
| stb_hs | input | 1 | High-speed oscillator enable strobe |
| stb_ext | input | 1 | External clock strobe, synchronized and edge-detected upstream |
| tick16_o | output | 1 | 16x sampling tick, one-cycle pulse |
| tick1_o | output | 1 | Bit-rate tick, one-cycle pulse |

## Verification
Some properties are checked on every cycle. Both ticks must be silent after a cycle with the enable low. The counter must step down by exactly one on each passed strobe. The frame position must advance by one on every underflow. The bit tick may appear only together with a sampling tick. The prescaler must be cleared while the generator is off.

Other behaviours need whole sequences of strobes, and only the bench's scenarios can show them. These include the exact period length for each reload value, the prescale ratio for each source, the placement of the trimmed periods within a frame, the deferred effect of a reload change, and the restart at period 0 after the enable is toggled. The bench compares both outputs on every cycle against a model that counts passed strobes against the expected period length.

// File: rtl/utg_pkg.sv
// Package: shared types for the UART transfer-clock generator.
// Assumes: source codes are fixed by the select field encoding.
package utg_pkg;

    // Source select encoding
    typedef enum logic [1:0] {
        SRC_INT = 2'd0,
        SRC_LS  = 2'd1,
        SRC_HS  = 2'd2,
        SRC_EXT = 2'd3
    } src_e;

    // True when the source is followed by the power-of-two prescaler
    function automatic logic src_scaled(input src_e s);
        return (s == SRC_INT) || (s == SRC_HS);
    endfunction

endpackage

// File: rtl/utg_src_sel.sv
// Module: utg_src_sel
// Picks one of four strobes. For the internal and high-speed sources it
// passes only every 2^div_sel-th strobe.
// Assumes: all strobes are single-cycle enables in the clk domain. The
// prescale count restarts whenever the generator is disabled.
module utg_src_sel
    import utg_pkg::*;
#(
    parameter int PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [1:0]       src_i,
    input  logic [PRE_W-1:0] div_i,
    input  logic [3:0]       stb_i,
    output logic             pass_o
);
    localparam int MAX_SH = (1 << PRE_W) - 1;
    localparam int PC_W   = (MAX_SH > 0) ? MAX_SH : 1;

    src_e            src;
    logic            raw;
    logic            scaled;
    logic [PC_W-1:0] pre_q;
    logic [PC_W-1:0] mask;

    // Decode the selected strobe and the prescale mask
    always_comb begin
        src    = src_e'(src_i);
        raw    = stb_i[src_i];
        scaled = src_scaled(src);
        mask   = ~({PC_W{1'b1}} << div_i);
        pass_o = en_i && raw && (!scaled || ((pre_q & mask) == mask));
    end

    // Count selected strobes for the prescaler
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (!en_i)
            pre_q <= '0;
        else if (raw && scaled)
            pre_q <= pre_q + 1'b1;
    end

    // R7: prescaler is restarted while disabled
    a_r7_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pre_q == '0));

endmodule

// File: rtl/utg_down_cnt.sv
// Module: utg_down_cnt
// Reloadable down counter. It loads reload_i on the first enabled cycle
// (ignoring that cycle's strobe) and on each underflow. One extra strobe
// is consumed in periods picked by the trim spread.
// Assumes: slot_i is the frame position of the current period.
module utg_down_cnt #(
    parameter int CNT_W  = 8,
    parameter int TRIM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              pass_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [TRIM_W-1:0] trim_i,
    input  logic [TRIM_W-1:0] slot_i,
    output logic              uf_o,
    output logic              tick16_o
);
    localparam int PW = 2 * TRIM_W;

    logic [CNT_W-1:0] cnt_q;
    logic             extra_q;
    logic             loaded_q;

    // True when period 'slot' of the frame gets one extra strobe for trim n
    function automatic logic trim_hit(input logic [TRIM_W-1:0] slot,
                                      input logic [TRIM_W-1:0] n);
        logic [PW-1:0] p0;
        logic [PW-1:0] p1;
        p0 = PW'(slot) * PW'(n);
        p1 = p0 + PW'(n);
        return p1[PW-1:TRIM_W] != p0[PW-1:TRIM_W];
    endfunction

    // Underflow: last strobe of the period arrives
    always_comb begin
        uf_o = en_i && loaded_q && pass_i && (cnt_q == '0) && !extra_q;
    end

    // Load, count down, take the trim strobe, reload on underflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            extra_q  <= 1'b0;
            loaded_q <= 1'b0;
            tick16_o <= 1'b0;
        end else begin
            tick16_o <= uf_o;
            if (!en_i) begin
                loaded_q <= 1'b0;
            end else if (!loaded_q) begin
                loaded_q <= 1'b1;
                cnt_q    <= reload_i;
                extra_q  <= trim_hit('0, trim_i);
            end else if (pass_i) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end else if (extra_q) begin
                    extra_q <= 1'b0;
                end else begin
                    cnt_q   <= reload_i;
                    extra_q <= trim_hit(slot_i + 1'b1, trim_i);
                end
            end
        end
    end

    // R3: each passed strobe steps a nonzero count down by one
    a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && loaded_q && pass_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: no sampling tick after a disabled cycle
    a_r7_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !tick16_o);

endmodule

// File: rtl/utg_frame_div.sv
// Module: utg_frame_div
// Divide-by-16 frame counter. It tracks the period position in the frame
// and flags the underflow that ends the last period.
// Assumes: uf_i is a single-cycle underflow strobe. Cleared when disabled.
module utg_frame_div #(
    parameter int TRIM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              uf_i,
    output logic [TRIM_W-1:0] slot_o,
    output logic              tick1_o
);
    // Advance the frame position and emit the bit-rate tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_o  <= '0;
            tick1_o <= 1'b0;
        end else begin
            tick1_o <= uf_i && (slot_o == {TRIM_W{1'b1}});
            if (!en_i)
                slot_o <= '0;
            else if (uf_i)
                slot_o <= slot_o + 1'b1;
        end
    end

    // R6: frame position steps once per underflow
    a_r6_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && uf_i) |=> (slot_o == $past(slot_o) + 1'b1));

    // R7: frame restarts while disabled
    a_r7_slot_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (slot_o == '0));

endmodule

// File: rtl/uart_tick_gen.sv
// Module: uart_tick_gen (top)
// UART transfer-clock generator: source select, optional prescaler,
// trimmed reloadable down counter, and divide-by-16 bit tick.
// Assumes: the strobes are synchronous enables. The frame length is 2^TRIM_W.
module uart_tick_gen #(
    parameter int CNT_W  = 8,
    parameter int TRIM_W = 4,
    parameter int PRE_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en,
    input  logic [1:0]        src_sel,
    input  logic [PRE_W-1:0]  div_sel,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              stb_int,
    input  logic              stb_ls,
    input  logic              stb_hs,
    input  logic              stb_ext,
    output logic              tick16_o,
    output logic              tick1_o
);
    logic [3:0]        stb_vec;
    logic              pass;
    logic              uf;
    logic [TRIM_W-1:0] slot;

    // Order strobes by their source code
    always_comb begin
        stb_vec = {stb_ext, stb_hs, stb_ls, stb_int};
    end

    utg_src_sel #(.PRE_W(PRE_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en), .src_i(src_sel),
        .div_i(div_sel), .stb_i(stb_vec), .pass_o(pass)
    );

    utg_down_cnt #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en), .pass_i(pass),
        .reload_i(reload_val), .trim_i(trim_val), .slot_i(slot),
        .uf_o(uf), .tick16_o(tick16_o)
    );

    utg_frame_div #(.TRIM_W(TRIM_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en_i(gen_en), .uf_i(uf),
        .slot_o(slot), .tick1_o(tick1_o)
    );

    // R6: the bit tick only comes with a sampling tick
    a_r6_tick1_with16: assert property (@(posedge clk) disable iff (!rst_n)
        tick1_o |-> tick16_o);

    // R1: reset leaves both ticks low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!tick16_o && !tick1_o));

endmodule

// File: tb/uart_tick_gen_test.sv
// Bench for uart_tick_gen: directed corners plus seeded random stimulus.
// It checks both ticks every cycle against a strobe-counting model.
module uart_tick_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gen_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] div_sel = 2'd0;
    logic [7:0] reload_val = 8'd0;
    logic [3:0] trim_val = 4'd0;
    logic       stb_int = 1'b0, stb_ls = 1'b0, stb_hs = 1'b0, stb_ext = 1'b0;
    logic       tick16_o, tick1_o;

    int checks = 0;
    int fails  = 0;
    string tag = "R1";

    // model state
    bit m_loaded;
    int m_pre, m_k, m_len, m_idx;

    uart_tick_gen uut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .src_sel(src_sel),
        .div_sel(div_sel), .reload_val(reload_val), .trim_val(trim_val),
        .stb_int(stb_int), .stb_ls(stb_ls), .stb_hs(stb_hs), .stb_ext(stb_ext),
        .tick16_o(tick16_o), .tick1_o(tick1_o)
    );

    always #5 clk = ~clk;

    function automatic int extra_for(input int k, input int n);
        return (((k + 1) * n) / 16 != (k * n) / 16) ? 1 : 0;
    endfunction

    // Model one rising edge with the inputs now applied; give expected outputs
    task automatic model_edge(output bit e16, output bit e1);
        bit s, sc, ps;
        int ratio;
        e16 = 0; e1 = 0;
        if (!rst_n) begin
            m_loaded = 0; m_pre = 0; m_idx = 0; m_k = 0;
        end else if (!gen_en) begin
            m_loaded = 0; m_pre = 0; m_idx = 0;
        end else begin
            case (src_sel)
                2'd0: s = stb_int;
                2'd1: s = stb_ls;
                2'd2: s = stb_hs;
                default: s = stb_ext;
            endcase
            sc = (src_sel == 2'd0) || (src_sel == 2'd2);
            ratio = 1 << div_sel;
            ps = s && (!sc || ((m_pre % ratio) == ratio - 1));
            if (s && sc) m_pre = (m_pre + 1) % 8;
            if (!m_loaded) begin
                m_loaded = 1; m_k = 0; m_idx = 0;
                m_len = int'(reload_val) + 1 + extra_for(0, int'(trim_val));
            end else if (ps) begin
                m_k++;
                if (m_k == m_len) begin
                    e16 = 1;
                    e1 = (m_idx == 15);
                    m_idx = (m_idx + 1) % 16;
                    m_k = 0;
                    m_len = int'(reload_val) + 1 + extra_for(m_idx, int'(trim_val));
                end
            end
        end
    endtask

    // Apply strobes, let one edge pass, then compare outputs at the next negedge
    task automatic step(input logic [3:0] s);
        bit e16, e1;
        {stb_ext, stb_hs, stb_ls, stb_int} = s;
        @(negedge clk);
        model_edge(e16, e1);
        checks++;
        if (tick16_o !== e16 || tick1_o !== e1) begin
            fails++;
            $display("FAIL %s cycle-check: tick16=%b tick1=%b expected tick16=%b tick1=%b",
                     tag, tick16_o, tick1_o, e16, e1);
        end
    endtask

    task automatic run_rand(input int n, input int density, input logic [3:0] allow);
        for (int i = 0; i < n; i++) begin
            logic [3:0] s;
            for (int b = 0; b < 4; b++) s[b] = (($urandom % 8) < density);
            step(s & allow);
        end
    endtask

    task automatic run_const(input int n, input logic [3:0] s);
        for (int i = 0; i < n; i++) step(s);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset and idle
        tag = "R1";
        gen_en = 1'b1;
        run_rand(6, 4, 4'hF);
        rst_n = 1'b1; gen_en = 1'b0;
        run_rand(30, 6, 4'hF);

        // R3: periods of reload+1 strobes, external source
        tag = "R3";
        src_sel = 2'd3; reload_val = 8'd0; gen_en = 1'b1;
        run_const(20, 4'hF);
        gen_en = 1'b0; step(4'h0);
        reload_val = 8'd9; gen_en = 1'b1;
        run_const(60, 4'h8);
        run_rand(100, 3, 4'hF);

        // R2: unselected strobes have no effect
        tag = "R2";
        src_sel = 2'd1; reload_val = 8'd2;
        run_const(80, 4'hD);
        run_rand(100, 4, 4'hF);
        src_sel = 2'd2;
        run_const(60, 4'hB);
        run_rand(80, 4, 4'hF);

        // R4: prescale ratios for each source
        tag = "R4";
        reload_val = 8'd1;
        for (int sv = 0; sv < 4; sv++) begin
            for (int dv = 0; dv < 4; dv++) begin
                gen_en = 1'b0; step(4'h0);
                src_sel = 2'(sv); div_sel = 2'(dv); gen_en = 1'b1;
                run_const(70, 4'hF);
            end
        end

        // R5 and R6: trim spread across frames
        tag = "R5";
        src_sel = 2'd1; div_sel = 2'd0; reload_val = 8'd2;
        foreach (trim_list[i]) begin
            gen_en = 1'b0; step(4'h0);
            trim_val = trim_list[i]; gen_en = 1'b1;
            run_const(160, 4'hF);
        end
        tag = "R6";
        trim_val = 4'd5; reload_val = 8'd0;
        run_const(120, 4'h2);

        // R8: reload change mid-period
        tag = "R8";
        gen_en = 1'b0; step(4'h0);
        trim_val = 4'd0; reload_val = 8'd6; gen_en = 1'b1;
        run_const(3, 4'h2);
        reload_val = 8'd2;
        run_const(30, 4'h2);
        reload_val = 8'd11;
        run_const(5, 4'h2);
        reload_val = 8'd3;
        run_const(40, 4'h2);

        // R7: enable toggling during activity
        tag = "R7";
        for (int i = 0; i < 30; i++) begin
            gen_en = ($urandom % 4) != 0;
            run_rand(1 + ($urandom % 40), 5, 4'hF);
        end

        // Mixed random configurations
        for (int i = 0; i < 40; i++) begin
            tag = (i % 2 == 0) ? "R5" : "R4";
            src_sel = 2'($urandom); div_sel = 2'($urandom);
            reload_val = 8'($urandom % 12); trim_val = 4'($urandom);
            gen_en = ($urandom % 8) != 0;
            run_rand(200, 1 + ($urandom % 7), 4'hF);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [3:0] trim_list [4] = '{4'd1, 4'd8, 4'd15, 4'd3};

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule